// File: doc/BRIEF.md
# Memory Interface Clock-Gating Controller

This block produces the clock enables for the internal clock domains of an external memory interface controller, and the enable for the clock driven out to a synchronous-burst SRAM. Four domains are served: one clock per memory port, the CPU/DMA pipeline and stall logic, the main datapath (arbitration, scheduling, external address and data), and the SRAM output clock. A four-bit gating configuration chooses, per domain, between aggressive gating that follows the activity flags and conservative gating that stops the clock only while the controller is idle or holding. The enables feed AND-style gating cells outside this block.

Each enable is captured on the falling edge of the controller clock, so a gating cell never sees it change while the clock is high. A pending request in an aggressively gated domain raises its enable at once, without waiting for the falling edge. The SRAM path has a warm-up counter: an SRAM access may start only after the SRAM clock has passed two rising edges in a row. Any edge with the clock stopped restarts that count.

Top module: `memif_clkgate`

## Requirements
- R1: With gating bit 0 set, `portClkEn[i]` is high exactly when `portPend[i]` or `portAct[i]` is high.
- R2: When gating bit 0, 1 or 2 is clear, the port, CPU or main enable (respectively) is low exactly when `ctrlState` is IDLE (2'b00) or HOLD (2'b01). The states BUSY (2'b10) and REFRESH (2'b11) keep the enable high.
- R3: With gating bit 1 set, `cpuClkEn` is high exactly when `reqIn`, any `portPend` bit or any `portAct` bit is high.
- R4: With gating bit 2 set, `mainClkEn` is high exactly when any `portPend` bit or any `portAct` bit is high.
- R5: With gating bit 3 set, `sramClkEn` equals `sramSwEn` AND `sramPend`. With bit 3 clear it equals `sramSwEn`.
- R6: `sramReady` goes high after two consecutive rising clock edges with `sramClkEn` high. A rising edge with `sramClkEn` low clears it.
- R7: `sramStart` is high exactly when `sramPend`, `sramReady` and `sramClkEn` are all high.
- R8: While `rstN` is low, every clock enable is high and `sramReady` and `sramStart` are low.
- R9: An enable that is to fall changes only at the falling clock edge. An aggressive-mode wake term raises its enable in the same cycle as its input. The wake terms are `portPend[i]` (bit 0), `reqIn` or any pend (bit 1), any pend (bit 2), and `sramSwEn & sramPend` (bit 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| gateCfg | input | 4 | Aggressive-gating bits: 0 ports, 1 CPU, 2 main, 3 SRAM |
| ctrlState | input | 2 | Controller state: 00 IDLE, 01 HOLD, 10 BUSY, 11 REFRESH |
| portPend | input | NUM_PORTS | Access pending per memory port |
| portAct | input | NUM_PORTS | Access in progress per memory port |
| reqIn | input | 1 | A request input from CPU/DMA is asserted |
| sramPend | input | 1 | SRAM access pending |
| sramSwEn | input | 1 | Software SRAM clock-enable bit |
| portClkEn | output | NUM_PORTS | Clock enable per memory port |
| cpuClkEn | output | 1 | CPU/DMA pipeline clock enable |
| mainClkEn | output | 1 | Main datapath clock enable |
| sramClkEn | output | 1 | SRAM output clock enable |
| sramReady | output | 1 | SRAM clock has warmed up |
| sramStart | output | 1 | SRAM access may start |

## Verification
The hardest situation to reach is the narrow window between a rising edge and the next falling edge. In that window a falling enable must keep its old value, while a waking one must already be high. The bench changes inputs one nanosecond after each rising edge and samples twice: once before the falling edge, against the previous enable ORed with the wake terms, and once late in the cycle. The warm-up counter is driven by stretches of random SRAM pending and software-enable bits in aggressive mode, which stop the clock for single cycles. A reset in the middle of the run checks that the counter is cleared and that the enables are forced on.

// File: rtl/memif_clkgate_pkg.sv
`timescale 1ns/1ps
package memif_clkgate_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'b00,
    ST_HOLD    = 2'b01,
    ST_BUSY    = 2'b10,
    ST_REFRESH = 2'b11
  } ctrlState_e;

  localparam int CFG_PORT = 0;
  localparam int CFG_CPU  = 1;
  localparam int CFG_MAIN = 2;
  localparam int CFG_SRAM = 3;
  localparam int CFG_BITS = 4;

  typedef struct packed {
    logic cpuNeed;
    logic cpuWake;
    logic mainNeed;
    logic mainWake;
    logic sramNeed;
    logic sramWake;
  } gateStrobe_t;

  function automatic logic isQuiet(input logic [1:0] st);
    return (st == ST_IDLE) || (st == ST_HOLD);
  endfunction

endpackage

// File: rtl/memif_clkgate_ctrl.sv
`timescale 1ns/1ps
module memif_clkgate_ctrl
  import memif_clkgate_pkg::*;
#(
  parameter int NUM_PORTS = 2
) (
  input  logic [CFG_BITS-1:0]  gateCfg,
  input  logic [1:0]           ctrlState,
  input  logic [NUM_PORTS-1:0] portPend,
  input  logic [NUM_PORTS-1:0] portAct,
  input  logic                 reqIn,
  input  logic                 sramPend,
  input  logic                 sramSwEn,
  output logic [NUM_PORTS-1:0] portNeed,
  output logic [NUM_PORTS-1:0] portWake,
  output gateStrobe_t          strobe
);

  logic quiet;
  logic anyPend;
  logic anyAct;

  assign quiet   = isQuiet(ctrlState);
  assign anyPend = |portPend;
  assign anyAct  = |portAct;

  // per-port rule: activity on that port only
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    always_comb begin
      if (gateCfg[CFG_PORT]) begin
        portNeed[p] = portPend[p] | portAct[p];
        portWake[p] = portPend[p];
      end else begin
        portNeed[p] = ~quiet;
        portWake[p] = 1'b0;
      end
    end
  end

  always_comb begin
    strobe = '0;
    if (gateCfg[CFG_CPU]) begin
      strobe.cpuNeed = reqIn | anyPend | anyAct;
      strobe.cpuWake = reqIn | anyPend;
    end else begin
      strobe.cpuNeed = ~quiet;
    end
    if (gateCfg[CFG_MAIN]) begin
      strobe.mainNeed = anyPend | anyAct;
      strobe.mainWake = anyPend;
    end else begin
      strobe.mainNeed = ~quiet;
    end
    if (gateCfg[CFG_SRAM]) begin
      strobe.sramNeed = sramSwEn & sramPend;
      strobe.sramWake = sramSwEn & sramPend;
    end else begin
      strobe.sramNeed = sramSwEn;
    end
  end

endmodule

// File: rtl/memif_clkgate_dp.sv
`timescale 1ns/1ps
module memif_clkgate_dp
  import memif_clkgate_pkg::*;
#(
  parameter int NUM_PORTS   = 2,
  parameter int WARM_CYCLES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_PORTS-1:0] portNeed,
  input  logic [NUM_PORTS-1:0] portWake,
  input  gateStrobe_t          strobe,
  input  logic                 sramPend,
  output logic [NUM_PORTS-1:0] portClkEn,
  output logic                 cpuClkEn,
  output logic                 mainClkEn,
  output logic                 sramClkEn,
  output logic                 sramReady,
  output logic                 sramStart
);

  localparam int CNT_W = $clog2(WARM_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(WARM_CYCLES);

  logic [NUM_PORTS-1:0] portEnQ;
  logic                 cpuEnQ;
  logic                 mainEnQ;
  logic                 sramEnQ;
  logic [CNT_W-1:0]     warmCnt;

  // enables captured while the clock is low
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_portEn
    always_ff @(negedge clk or negedge rstN) begin
      if (!rstN) portEnQ[p] <= 1'b1;
      else       portEnQ[p] <= portNeed[p];
    end
    assign portClkEn[p] = portEnQ[p] | (rstN & portWake[p]);
  end

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      cpuEnQ  <= 1'b1;
      mainEnQ <= 1'b1;
      sramEnQ <= 1'b1;
    end else begin
      cpuEnQ  <= strobe.cpuNeed;
      mainEnQ <= strobe.mainNeed;
      sramEnQ <= strobe.sramNeed;
    end
  end

  assign cpuClkEn  = cpuEnQ  | (rstN & strobe.cpuWake);
  assign mainClkEn = mainEnQ | (rstN & strobe.mainWake);
  assign sramClkEn = sramEnQ | (rstN & strobe.sramWake);

  // warm-up: count SRAM clock edges that actually reach the device
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               warmCnt <= '0;
    else if (!sramClkEn)     warmCnt <= '0;
    else if (warmCnt != CNT_TOP) warmCnt <= warmCnt + 1'b1;
  end

  assign sramReady = (warmCnt == CNT_TOP);
  assign sramStart = sramPend & sramReady & sramClkEn;

  assert_ready_cleared_R6: assert property (
    @(posedge clk) disable iff (!rstN) !sramClkEn |=> !sramReady);

  assert_start_after_clock_R7: assert property (
    @(posedge clk) disable iff (!rstN) sramStart |-> $past(sramClkEn));

  assert_ready_follows_run_R6: assert property (
    @(posedge clk) disable iff (!rstN) $rose(sramReady) |-> $past(sramClkEn));

endmodule

// File: rtl/memif_clkgate.sv
`timescale 1ns/1ps
module memif_clkgate
  import memif_clkgate_pkg::*;
#(
  parameter int NUM_PORTS   = 2,
  parameter int WARM_CYCLES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [3:0]           gateCfg,
  input  logic [1:0]           ctrlState,
  input  logic [NUM_PORTS-1:0] portPend,
  input  logic [NUM_PORTS-1:0] portAct,
  input  logic                 reqIn,
  input  logic                 sramPend,
  input  logic                 sramSwEn,
  output logic [NUM_PORTS-1:0] portClkEn,
  output logic                 cpuClkEn,
  output logic                 mainClkEn,
  output logic                 sramClkEn,
  output logic                 sramReady,
  output logic                 sramStart
);

  logic [NUM_PORTS-1:0] portNeed;
  logic [NUM_PORTS-1:0] portWake;
  gateStrobe_t          strobe;

  memif_clkgate_ctrl #(.NUM_PORTS(NUM_PORTS)) u_ctrl (
    .gateCfg   (gateCfg),
    .ctrlState (ctrlState),
    .portPend  (portPend),
    .portAct   (portAct),
    .reqIn     (reqIn),
    .sramPend  (sramPend),
    .sramSwEn  (sramSwEn),
    .portNeed  (portNeed),
    .portWake  (portWake),
    .strobe    (strobe)
  );

  memif_clkgate_dp #(.NUM_PORTS(NUM_PORTS), .WARM_CYCLES(WARM_CYCLES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .portNeed  (portNeed),
    .portWake  (portWake),
    .strobe    (strobe),
    .sramPend  (sramPend),
    .portClkEn (portClkEn),
    .cpuClkEn  (cpuClkEn),
    .mainClkEn (mainClkEn),
    .sramClkEn (sramClkEn),
    .sramReady (sramReady),
    .sramStart (sramStart)
  );

  assert_cpu_request_wakes_R3: assert property (
    @(posedge clk) disable iff (!rstN) (gateCfg[1] && reqIn) |-> cpuClkEn);

  assert_main_busy_runs_R2: assert property (
    @(posedge clk) disable iff (!rstN)
    (!gateCfg[2] && ctrlState == 2'b10) |-> mainClkEn);

  assert_sram_sw_off_R5: assert property (
    @(posedge clk) disable iff (!rstN) (!gateCfg[3] && !sramSwEn) |-> !sramClkEn);

  assert_port_pend_wakes_R1: assert property (
    @(posedge clk) disable iff (!rstN)
    gateCfg[0] |-> ((portClkEn & portPend) == portPend));

endmodule

// File: tb/memif_clkgate_bench.sv
`timescale 1ns/1ps
module memif_clkgate_bench;

  localparam int NP = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [3:0]    gateCfg = 4'h0;
  logic [1:0]    ctrlState = 2'b00;
  logic [NP-1:0] portPend = '0;
  logic [NP-1:0] portAct = '0;
  logic          reqIn = 1'b0;
  logic          sramPend = 1'b0;
  logic          sramSwEn = 1'b1;
  logic [NP-1:0] portClkEn;
  logic          cpuClkEn, mainClkEn, sramClkEn, sramReady, sramStart;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // model state
  int warm = 0;
  bit prevPort[NP];
  bit prevCpu = 1, prevMain = 1, prevSram = 1;

  always #2 clk = ~clk;

  memif_clkgate #(.NUM_PORTS(NP), .WARM_CYCLES(2)) u_memif_clkgate (
    .clk(clk), .rstN(rstN), .gateCfg(gateCfg), .ctrlState(ctrlState),
    .portPend(portPend), .portAct(portAct), .reqIn(reqIn), .sramPend(sramPend),
    .sramSwEn(sramSwEn), .portClkEn(portClkEn), .cpuClkEn(cpuClkEn),
    .mainClkEn(mainClkEn), .sramClkEn(sramClkEn), .sramReady(sramReady),
    .sramStart(sramStart));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  function automatic bit quietSt();
    return ctrlState == 2'b00 || ctrlState == 2'b01;
  endfunction

  function automatic bit portNeedM(int p);
    return gateCfg[0] ? (portPend[p] || portAct[p]) : !quietSt();
  endfunction
  function automatic bit cpuNeedM();
    return gateCfg[1] ? (reqIn || portPend != 0 || portAct != 0) : !quietSt();
  endfunction
  function automatic bit mainNeedM();
    return gateCfg[2] ? (portPend != 0 || portAct != 0) : !quietSt();
  endfunction
  function automatic bit sramNeedM();
    return gateCfg[3] ? (sramSwEn && sramPend) : sramSwEn;
  endfunction

  // one cycle: edge bookkeeping, drive, mid-cycle check, late check
  task automatic step(input bit nRst, input logic [3:0] cfg, input logic [1:0] st,
                      input logic [NP-1:0] pp, input logic [NP-1:0] pa,
                      input bit rq, input bit sp, input bit sw);
    bit expSram;
    @(posedge clk);
    if (!rstN) warm = 0;
    else if (prevSram) warm = (warm < 2) ? warm + 1 : 2;
    else warm = 0;
    #1;
    rstN = nRst; gateCfg = cfg; ctrlState = st; portPend = pp; portAct = pa;
    reqIn = rq; sramPend = sp; sramSwEn = sw;
    if (!rstN) warm = 0;
    #0.5;
    // R9: before the falling edge only wake terms may have changed enables
    if (rstN) begin
      for (int p = 0; p < NP; p++)
        chk(portClkEn[p] == (prevPort[p] || (gateCfg[0] && portPend[p])),
            "R9 port pre-negedge", portClkEn[p], prevPort[p] || (gateCfg[0] && portPend[p]));
      chk(cpuClkEn == (prevCpu || (gateCfg[1] && (reqIn || portPend != 0))),
          "R9 cpu pre-negedge", cpuClkEn, prevCpu || (gateCfg[1] && (reqIn || portPend != 0)));
      chk(mainClkEn == (prevMain || (gateCfg[2] && portPend != 0)),
          "R9 main pre-negedge", mainClkEn, prevMain || (gateCfg[2] && portPend != 0));
      chk(sramClkEn == (prevSram || (gateCfg[3] && sramSwEn && sramPend)),
          "R9 sram pre-negedge", sramClkEn, prevSram || (gateCfg[3] && sramSwEn && sramPend));
    end
    #1.5;
    if (!rstN) begin
      for (int p = 0; p < NP; p++) begin
        chk(portClkEn[p] == 1'b1, "R8 port enable in reset", portClkEn[p], 1);
        prevPort[p] = 1;
      end
      chk(cpuClkEn == 1'b1, "R8 cpu enable in reset", cpuClkEn, 1);
      chk(mainClkEn == 1'b1, "R8 main enable in reset", mainClkEn, 1);
      chk(sramClkEn == 1'b1, "R8 sram enable in reset", sramClkEn, 1);
      chk(sramReady == 1'b0, "R8 ready in reset", sramReady, 0);
      chk(sramStart == 1'b0, "R8 start in reset", sramStart, 0);
      prevCpu = 1; prevMain = 1; prevSram = 1;
    end else begin
      for (int p = 0; p < NP; p++) begin
        chk(portClkEn[p] == portNeedM(p), gateCfg[0] ? "R1 port enable" : "R2 port enable",
            portClkEn[p], portNeedM(p));
        prevPort[p] = portNeedM(p);
      end
      chk(cpuClkEn == cpuNeedM(), gateCfg[1] ? "R3 cpu enable" : "R2 cpu enable",
          cpuClkEn, cpuNeedM());
      chk(mainClkEn == mainNeedM(), gateCfg[2] ? "R4 main enable" : "R2 main enable",
          mainClkEn, mainNeedM());
      expSram = sramNeedM();
      chk(sramClkEn == expSram, "R5 sram enable", sramClkEn, expSram);
      chk(sramReady == (warm >= 2), "R6 sram ready", sramReady, warm >= 2);
      chk(sramStart == (sramPend && warm >= 2 && expSram), "R7 sram start",
          sramStart, sramPend && warm >= 2 && expSram);
      prevCpu = cpuNeedM(); prevMain = mainNeedM(); prevSram = expSram;
    end
  endtask

  initial begin
    for (int p = 0; p < NP; p++) prevPort[p] = 1;
    repeat (3) step(0, 4'h0, 2'b00, '0, '0, 0, 0, 1);
    // conservative mode across every controller state (R2)
    for (int s = 0; s < 4; s++) step(1, 4'h0, 2'(s), '0, '0, 0, 0, 1);
    step(1, 4'h0, 2'b10, 2'b01, 2'b10, 1, 0, 1);
    step(1, 4'h0, 2'b01, 2'b11, 2'b11, 1, 1, 1);
    // aggressive ports/cpu/main (R1 R3 R4), idle to wake transitions (R9)
    step(1, 4'h7, 2'b10, '0, '0, 0, 0, 1);
    step(1, 4'h7, 2'b10, 2'b01, '0, 0, 0, 1);
    step(1, 4'h7, 2'b10, '0, 2'b01, 0, 0, 1);
    step(1, 4'h7, 2'b00, '0, '0, 1, 0, 1);
    step(1, 4'h7, 2'b00, '0, '0, 0, 0, 1);
    step(1, 4'h7, 2'b10, 2'b10, 2'b00, 0, 0, 1);
    // SRAM: software bit only, then aggressive with warm-up (R5 R6 R7)
    step(1, 4'h0, 2'b10, '0, '0, 0, 1, 0);
    step(1, 4'h0, 2'b10, '0, '0, 0, 1, 1);
    step(1, 4'h0, 2'b10, '0, '0, 0, 1, 1);
    step(1, 4'h0, 2'b10, '0, '0, 0, 1, 1);
    step(1, 4'h8, 2'b10, '0, '0, 0, 0, 1);
    step(1, 4'h8, 2'b10, '0, '0, 0, 1, 1);
    step(1, 4'h8, 2'b10, '0, '0, 0, 1, 1);
    step(1, 4'h8, 2'b10, '0, '0, 0, 1, 1);
    step(1, 4'h8, 2'b10, '0, '0, 0, 0, 1);
    step(1, 4'h8, 2'b10, '0, '0, 0, 1, 1);
    step(1, 4'h8, 2'b10, '0, '0, 0, 1, 1);
    // random traffic
    for (int i = 0; i < 400; i++)
      step(1, 4'($urandom), 2'($urandom), NP'($urandom), NP'($urandom),
           1'($urandom), ($urandom % 4) != 0, ($urandom % 5) != 0);
    // reset in mid run clears warm-up (R8)
    step(0, 4'hF, 2'b10, '0, '0, 0, 1, 1);
    step(0, 4'hF, 2'b10, '0, '0, 0, 1, 1);
    for (int i = 0; i < 4; i++) step(1, 4'hF, 2'b10, '0, '0, 0, 1, 1);
    for (int i = 0; i < 200; i++)
      step(1, 4'($urandom), 2'($urandom), NP'($urandom), NP'($urandom),
           1'($urandom), 1'($urandom), ($urandom % 3) != 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule